// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of an 8-bit successive-approximation converter that returns its result over a three-wire serial link. A one-cycle start request makes it pull the active-low select line low. It then holds the serial clock high for an acquisition window, so the converter's track-and-hold can settle. Next it produces exactly twelve serial clock pulses from a divided system clock and samples the converter's data line on each rising edge.

The twelve-bit frame has four mandatory zero bits ahead of the eight result bits, most significant bit first. The controller checks the four leading bits and flags a frame error if any of them is set. It turns the eight result bits into a 9-bit value: zero-extended in unipolar mode, where the code is straight binary, and sign-extended in bipolar mode, where the code is two's complement. The select line is released one serial clock period after the last sample. A guard period then keeps the select line high for a minimum time. The result, the error flag and a one-cycle valid strobe are published when the guard period ends.

The acquisition window is programmable in system clock cycles and never drops below a floor parameter. The floor is sized so that the window is never shorter than 600 ns. The mode and the window length are captured when the start request is accepted.

Top module: `adc_rdout_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `cs_n_o` and `sclk_o` are 1, and `busy_o`, `valid_o`, `frame_err_o` and `result_o` are 0.
- R2: A start request taken while idle drives `cs_n_o` low and `busy_o` high at the next clock edge. `sclk_o` then stays high for at least max(`acq_cycles_i`, ACQ_MIN) clock cycles before its first falling edge. `acq_cycles_i` is captured with the start.
- R3: Each frame has exactly twelve rising edges of `sclk_o`. Successive rising edges are CLK_DIV system cycles apart, and `sclk_o` is high whenever `cs_n_o` is high.
- R4: `sdo_i` is sampled at each rising edge of `sclk_o`. The first four samples are the leading bits. The last eight samples are the result code, most significant bit first.
- R5: In unipolar mode (`bipolar_i` = 0 at start), `result_o` is {1'b0, code}.
- R6: In bipolar mode (`bipolar_i` = 1 at start), `result_o` is {code[7], code}. The mode is captured with the start, and later changes of `bipolar_i` do not affect the frame.
- R7: `frame_err_o` is 1 exactly when at least one of the four leading samples was 1. It is updated together with `valid_o`.
- R8: `cs_n_o` rises exactly CLK_DIV cycles after the twelfth rising edge of `sclk_o`.
- R9: `cs_n_o` stays high for at least 2*CLK_DIV cycles between frames, even when `start_i` is held high continuously.
- R10: `valid_o` is a one-cycle pulse issued 2*CLK_DIV cycles after `cs_n_o` rises. `busy_o` drops in the same cycle. `result_o` and `frame_err_o` hold their values until the next pulse.
- R11: A start request made while `busy_o` is high is ignored: it starts no extra frame and produces no extra valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion readout request, taken only while idle |
| bipolar_i | input | 1 | 1 selects two's complement coding, 0 straight binary |
| acq_cycles_i | input | ACQ_W | Requested acquisition window in system cycles |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low converter select |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | High from an accepted start until the valid pulse |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| frame_err_o | output | 1 | A leading frame bit was nonzero |
| result_o | output | 9 | Zero- or sign-extended conversion result |

## Verification
The bench targets the bipolar extremes 0x80, 0x7F and 0xFF. A design that zero-extends instead of copying bit 7 returns a positive value for a negative code. It uses requested windows just below, at and above the floor; a design that ignores the floor or misses the compare by one shortens acquisition. It flips the mode and window inputs right after each start; a design that does not capture them reformats or stretches the frame. It also holds start high across frames, which a design without a guard would turn into a short select-high gap. It sends frames with stray leading ones, which an off-by-one shift count would either drop or fold into the result. A second start made mid-frame, and a reset made mid-frame, catch a design that restarts or leaves the select line low.

// File: rtl/adc_rdout_pkg.sv
package adc_rdout_pkg;

  localparam int LEAD_BITS  = 4;
  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = LEAD_BITS + DATA_BITS;
  localparam int RES_BITS   = DATA_BITS + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_SHIFT,
    ST_HOLD,
    ST_GUARD
  } rd_state_e;

  // Widen the code: sign copy for two's complement, zero for straight binary.
  function automatic logic [RES_BITS-1:0] fmt_result(input logic [DATA_BITS-1:0] code,
                                                     input logic bip);
    return bip ? {code[DATA_BITS-1], code} : {1'b0, code};
  endfunction

  function automatic logic lead_error(input logic [LEAD_BITS-1:0] lead);
    return |lead;
  endfunction

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sclk_o,
  output logic rise_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] POS_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] POS_HIGH = DIV_W'(HALF);
  localparam logic [DIV_W-1:0] POS_RISE = DIV_W'(HALF - 1);

  logic [DIV_W-1:0] pos_q;
  logic [DIV_W-1:0] pos_nxt;
  logic             sclk_q;

  // Phase position inside one serial period: low half first, high half second.
  always_comb pos_nxt = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= POS_LAST;
      sclk_q <= 1'b1;
    end else if (!run_i) begin
      pos_q  <= POS_LAST;
      sclk_q <= 1'b1;
    end else begin
      pos_q  <= pos_nxt;
      sclk_q <= (pos_nxt >= POS_HIGH);
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = run_i && (pos_q == POS_RISE);

  AST_SCLK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> sclk_o); // R3
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> $rose(sclk_o)); // R3

endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
  parameter int FRAME_BITS = 12,
  parameter int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  shift_i,
  input  logic                  sdo_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic [CNT_W-1:0]      count_o
);
  logic [FRAME_BITS-1:0] frame_q;
  logic [CNT_W-1:0]      cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      frame_q <= '0;
      cnt_q   <= '0;
    end else if (shift_i) begin
      frame_q <= {frame_q[FRAME_BITS-2:0], sdo_i};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign frame_o = frame_q;
  assign count_o = cnt_q;

  AST_SHIFT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_i |-> (count_o < CNT_W'(FRAME_BITS))); // R3

endmodule

// File: rtl/adc_rdout_ctrl.sv
module adc_rdout_ctrl
  import adc_rdout_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ACQ_W   = 16,
  parameter int ACQ_MIN = 60
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                bipolar_i,
  input  logic [ACQ_W-1:0]    acq_cycles_i,
  input  logic                sdo_i,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic                busy_o,
  output logic                valid_o,
  output logic                frame_err_o,
  output logic [RES_BITS-1:0] result_o
);
  localparam int GUARD_CYC = 2 * CLK_DIV;
  localparam int TMR_W     = $clog2(GUARD_CYC + 1);
  localparam int CNT_W     = $clog2(FRAME_BITS + 1);
  localparam logic [ACQ_W-1:0] ACQ_FLOOR = ACQ_W'(ACQ_MIN);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);

  // Applied acquisition window: the request, but never under the floor.
  function automatic logic [ACQ_W-1:0] acq_window(input logic [ACQ_W-1:0] req);
    return (req < ACQ_FLOOR) ? ACQ_FLOOR : req;
  endfunction

  rd_state_e             st_q;
  logic [ACQ_W-1:0]      acq_cnt_q;
  logic [TMR_W-1:0]      tmr_q;
  logic                  cs_n_q;
  logic                  mode_q;
  logic                  valid_q;
  logic                  err_q;
  logic [RES_BITS-1:0]   result_q;
  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      bit_cnt;

  // Named internal events
  logic start_take;
  logic rise_evt;
  logic frame_done;
  logic acq_done;
  logic hold_done;
  logic guard_done;
  logic shift_run;

  assign start_take = (st_q == ST_IDLE) && start_i;
  assign shift_run  = (st_q == ST_SHIFT);
  assign frame_done = shift_run && rise_evt && (bit_cnt == LAST_BIT);
  assign acq_done   = (st_q == ST_ACQ) && (acq_cnt_q == '0);
  assign hold_done  = (st_q == ST_HOLD) && (tmr_q == '0);
  assign guard_done = (st_q == ST_GUARD) && (tmr_q == '0);

  adc_sclk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (shift_run),
    .sclk_o (sclk_o),
    .rise_o (rise_evt)
  );

  adc_frame_shifter #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_take),
    .shift_i (rise_evt),
    .sdo_i   (sdo_i),
    .frame_o (frame),
    .count_o (bit_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      acq_cnt_q <= '0;
      tmr_q     <= '0;
      cs_n_q    <= 1'b1;
      mode_q    <= 1'b0;
      valid_q   <= 1'b0;
      err_q     <= 1'b0;
      result_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_take) begin
            st_q      <= ST_ACQ;
            cs_n_q    <= 1'b0;
            mode_q    <= bipolar_i;
            acq_cnt_q <= acq_window(acq_cycles_i) - 1'b1;
          end
        end
        ST_ACQ: begin
          if (acq_done) st_q <= ST_SHIFT;
          else          acq_cnt_q <= acq_cnt_q - 1'b1;
        end
        ST_SHIFT: begin
          if (frame_done) begin
            st_q  <= ST_HOLD;
            tmr_q <= TMR_W'(CLK_DIV - 1);
          end
        end
        ST_HOLD: begin
          if (hold_done) begin
            st_q   <= ST_GUARD;
            cs_n_q <= 1'b1;
            tmr_q  <= TMR_W'(GUARD_CYC - 1);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        ST_GUARD: begin
          if (guard_done) begin
            st_q     <= ST_IDLE;
            valid_q  <= 1'b1;
            result_q <= fmt_result(frame[DATA_BITS-1:0], mode_q);
            err_q    <= lead_error(frame[FRAME_BITS-1 -: LEAD_BITS]);
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o      = cs_n_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign valid_o     = valid_q;
  assign frame_err_o = err_q;
  assign result_o    = result_q;

  // Assertion support: cycles with select low before the first serial fall,
  // and cycles with select high (saturating at the guard length).
  logic [ACQ_W-1:0] chk_low_age;
  logic             chk_fall_seen;
  logic [TMR_W-1:0] chk_high_age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_low_age   <= '0;
      chk_fall_seen <= 1'b0;
      chk_high_age  <= TMR_W'(GUARD_CYC);
    end else if (cs_n_o) begin
      chk_low_age   <= '0;
      chk_fall_seen <= 1'b0;
      if (chk_high_age < TMR_W'(GUARD_CYC)) chk_high_age <= chk_high_age + 1'b1;
    end else begin
      chk_high_age <= '0;
      if (chk_low_age != '1) chk_low_age <= chk_low_age + 1'b1;
      if (!sclk_o) chk_fall_seen <= 1'b1;
    end
  end

  AST_ACQ_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_fall_seen && $fell(sclk_o)) |-> (chk_low_age >= ACQ_FLOOR)); // R2
  AST_START_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $fell(cs_n_o)); // R2
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> cs_n_o); // R2
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o); // R3
  AST_GUARD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (chk_high_age >= TMR_W'(GUARD_CYC))); // R9
  AST_VALID_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (!busy_o && $past(busy_o))); // R10
  AST_UNI_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !mode_q) |-> !result_o[RES_BITS-1]); // R5
  AST_BIP_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && mode_q) |-> (result_o[RES_BITS-1] == result_o[RES_BITS-2])); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !$fell(cs_n_o)); // R11

endmodule

// File: tb/adc_rdout_ctrl_tb.sv
module adc_rdout_ctrl_tb;
  localparam int CLK_DIV = 4;
  localparam int ACQ_W   = 16;
  localparam int ACQ_MIN = 60;

  // {mode, acq[7:0], frame[11:0], exp_err, exp_res[8:0]}
  localparam logic [30:0] VEC [0:7] = '{
    {1'b0, 8'd0,   12'h000, 1'b0, 9'h000},
    {1'b0, 8'd59,  12'h0FF, 1'b0, 9'h0FF},
    {1'b0, 8'd61,  12'h0A5, 1'b0, 9'h0A5},
    {1'b1, 8'd60,  12'h080, 1'b0, 9'h180},
    {1'b1, 8'd200, 12'h07F, 1'b0, 9'h07F},
    {1'b1, 8'd1,   12'h0FF, 1'b0, 9'h1FF},
    {1'b0, 8'd70,  12'h83C, 1'b1, 9'h03C},
    {1'b1, 8'd0,   12'h1C3, 1'b1, 9'h1C3}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             bip = 1'b0;
  logic [ACQ_W-1:0] acq = '0;
  logic             sdo = 1'b0;
  logic             cs_n, sclk, busy, valid, ferr;
  logic [8:0]       res;

  adc_rdout_ctrl #(.CLK_DIV(CLK_DIV), .ACQ_W(ACQ_W), .ACQ_MIN(ACQ_MIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bipolar_i(bip),
    .acq_cycles_i(acq), .sdo_i(sdo), .cs_n_o(cs_n), .sclk_o(sclk),
    .busy_o(busy), .valid_o(valid), .frame_err_o(ferr), .result_o(res)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Converter model and edge monitor, sampled between clock edges.
  logic [11:0] slave_bits = '0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  int t_cs_fall = 0, t_cs_rise = 0, t_first_fall = 0, t_last_rise = 0, t_valid = 0;
  int n_rise = 0, n_fall = 0, n_cs_fall = 0, n_valid = 0, per_err = 0, park_err = 0, hi_gap = 0;

  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      t_cs_fall = cyc; n_rise = 0; n_fall = 0;
      hi_gap = cyc - t_cs_rise; n_cs_fall++;
    end
    if (!prev_cs && cs_n) t_cs_rise = cyc;
    if (prev_sclk && !sclk && !cs_n) begin
      if (n_fall == 0) t_first_fall = cyc;
      if (n_fall < 12) sdo = slave_bits[11 - n_fall];
      n_fall++;
    end
    if (!prev_sclk && sclk && !cs_n) begin
      if (n_rise > 0 && (cyc - t_last_rise) != CLK_DIV) per_err++;
      n_rise++; t_last_rise = cyc;
    end
    if (cs_n && !sclk) park_err++;
    if (valid) begin t_valid = cyc; n_valid++; end
    prev_cs = cs_n; prev_sclk = sclk;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic wait_valid(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (valid) begin seen = 1'b1; break; end
    end
  endtask

  task automatic do_frame(input logic mode, input int acq_v, input logic [11:0] bits,
                          input logic exp_err, input logic [8:0] exp_res);
    int eff, gap;
    bit seen;
    eff = (acq_v < ACQ_MIN) ? ACQ_MIN : acq_v;
    slave_bits = bits;
    @(negedge clk);
    bip = mode; acq = ACQ_W'(acq_v); start = 1'b1;
    @(negedge clk);
    start = 1'b0; bip = ~mode; acq = '0;   // captured values must persist
    check(!cs_n && busy, "R2 select and busy after start", {cs_n, busy}, 2'b01);
    wait_valid(seen);
    check(seen, "R10 valid pulse arrives", seen, 1);
    check(!busy, "R10 busy low with valid", busy, 0);
    @(negedge clk);
    check(!valid, "R10 valid is one cycle", valid, 0);
    gap = t_first_fall - t_cs_fall;
    check(gap >= eff && gap <= eff + CLK_DIV, "R2 acquisition window", gap, eff);
    check(n_rise == 12, "R3 rising edges per frame", n_rise, 12);
    check(per_err == 0 && park_err == 0, "R3 period and idle-high", per_err + park_err, 0);
    check(t_cs_rise - t_last_rise == CLK_DIV, "R8 select release", t_cs_rise - t_last_rise, CLK_DIV);
    check(t_valid - t_cs_rise == 2 * CLK_DIV, "R10 valid after guard", t_valid - t_cs_rise, 2 * CLK_DIV);
    check(ferr == exp_err, "R7 leading-bit error", ferr, exp_err);
    if (mode) check(res == exp_res, "R4 R6 bipolar result", res, exp_res);
    else      check(res == exp_res, "R4 R5 unipolar result", res, exp_res);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", cyc, 0);
    summary();
    $finish;
  end

  initial begin : main
    int c0, v0;
    bit seen;
    logic [8:0] held;
    repeat (3) @(negedge clk);
    check(cs_n && sclk && !busy && !valid && !ferr && res == 0, "R1 outputs in reset",
          {cs_n, sclk, busy, valid, ferr}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && sclk && !busy && !valid && res == 0, "R1 outputs after reset",
          {cs_n, sclk, busy, valid}, 4'b1100);

    for (int i = 0; i < 8; i++)
      do_frame(VEC[i][30], int'(VEC[i][29:22]), VEC[i][21:10], VEC[i][9], VEC[i][8:0]);

    // R9: start held high across two frames
    slave_bits = 12'h05A;
    c0 = n_cs_fall; v0 = n_valid;
    @(negedge clk); bip = 1'b0; acq = '0; start = 1'b1;
    wait_valid(seen);
    wait_valid(seen);
    start = 1'b0;
    @(negedge clk);
    check(n_cs_fall - c0 == 2, "R9 two frames back to back", n_cs_fall - c0, 2);
    check(hi_gap >= 2 * CLK_DIV, "R9 select high gap", hi_gap, 2 * CLK_DIV);
    check(res == 9'h05A, "R5 back-to-back result", res, 9'h05A);

    // R11: second request mid-frame is ignored
    repeat (20) @(negedge clk);
    slave_bits = 12'h0C4;
    c0 = n_cs_fall; v0 = n_valid;
    start = 1'b1; bip = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_valid(seen);
    held = res;
    repeat (300) @(negedge clk);
    check(n_cs_fall - c0 == 1, "R11 no extra frame", n_cs_fall - c0, 1);
    check(n_valid - v0 == 1, "R11 no extra valid", n_valid - v0, 1);
    check(held == 9'h1C4 && res == held, "R10 result held", res, 9'h1C4);

    // R1: reset in the middle of a frame
    slave_bits = 12'h033;
    start = 1'b1; bip = 1'b0;
    @(negedge clk); start = 1'b0;
    repeat (80) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(cs_n && sclk && !busy && !valid && !ferr && res == 0, "R1 mid-frame reset",
          {cs_n, sclk, busy, valid, ferr}, 5'b11000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_frame(1'b0, 0, 12'h033, 1'b0, 9'h033);

    summary();
    $finish;
  end

endmodule